// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. Each cycle it takes an operation code, a register operand (the accumulator or an index register) and a memory operand. It returns a result straight away, through combinational logic. When the caller marks the operation as issued, the block also updates a four-bit status word on the next clock edge. The status word holds negative, overflow, zero and carry.

The carry that add, subtract and the rotates consume is the block's own registered carry. A multi-byte add or subtract chain therefore only needs the operands issued on consecutive cycles. Each operation has a mask that names the flags it writes, and every other flag keeps its value. Compare and bit test change flags only. For them, and for the two unused codes, a result-write strobe tells the surrounding datapath not to store the result.

Top module: `alu8_flags`

## Requirements
- R1: A synchronous active-high reset clears N, V, Z and C on the clock edge where it is sampled high.
- R2: Add (op 1) gives A + M + C modulo 256. C becomes 1 when the unsigned sum exceeds 255. V becomes 1 when A and M share a sign and the result's sign differs from it. N is result bit 7 and Z is result == 0.
- R3: Subtract (op 2) gives A - M - (1 - C) modulo 256. C becomes 1 when no borrow occurs and 0 when a borrow occurs. V becomes 1 when A and M differ in sign and the result's sign differs from A. N and Z come from the result.
- R4: Compare (op 6) forms A - M with an implied carry-in of 1. Z becomes (A == M), C becomes (A >= M unsigned), N becomes bit 7 of the difference, and V is unchanged. `wr_result` is 0.
- R5: Bit test (op 7) sets Z when (A AND M) is zero, copies M bit 7 into N and M bit 6 into V, and leaves C unchanged. `wr_result` is 0.
- R6: Shift left (op 8) gives A << 1 with 0 shifted in, and C takes A bit 7. Logical shift right (op 9) gives A >> 1 with 0 shifted in, C takes A bit 0, and N always becomes 0. Z comes from the result.
- R7: Rotate left (op 10) gives {A[6:0], C} and C takes A bit 7. Rotate right (op 11) gives {C, A[7:1]} and C takes A bit 0. N and Z come from the result.
- R8: Pass (op 0), AND (op 3), OR (op 4), XOR (op 5), increment (op 12, A + 1) and decrement (op 13, A - 1) write only N (result bit 7) and Z (result == 0). V and C keep their values.
- R9: When `issue` is low, all four flags hold their value, whatever the operation code.
- R10: Codes 14 and 15 are no-operations. The result equals A, `wr_result` is 0, and no flag changes even when issued.
- R11: `wr_result` is 1 for every code except 6, 7, 14 and 15. The result of the current cycle uses the carry held before that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Apply this cycle's flag update on the next edge |
| op | input | 4 | Operation code |
| reg_opnd | input | 8 | Accumulator or index operand (A) |
| mem_opnd | input | 8 | Memory operand (M) |
| result | output | 8 | Combinational result |
| wr_result | output | 1 | Result is meant to be stored |
| flag_n | output | 1 | Registered negative flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |

## Verification
Two functions meet in one cycle: the carry-consuming datapath reads the registered carry while the same clock edge rewrites that carry from the current operation. The bench provokes this with back-to-back issued add, subtract and rotate operations, both in directed multi-byte chains and in random sequences where `issue` is high on most cycles. It judges each cycle's result against a reference model that advances its own carry only on issued edges. A design that forwards the new carry into the current result, or misses an update, then diverges on the following operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_CMP  = 4'd6,
        OP_BIT  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_ROL  = 4'd10,
        OP_ROR  = 4'd11,
        OP_INC  = 4'd12,
        OP_DEC  = 4'd13,
        OP_NOP0 = 4'd14,
        OP_NOP1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        SRC_ARITH = 2'd0,
        SRC_LOGIC = 2'd1,
        SRC_SHIFT = 2'd2
    } res_src_e;

    typedef struct packed {
        flags_t   wmask;
        logic     wr;
        res_src_e src;
        logic     bit_test;
    } op_ctrl_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] m,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             vout
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_opnd;
    logic             c_in;
    logic [WIDTH:0]   sum;

    always_comb begin
        b_opnd = m;
        c_in   = cin;
        unique case (op)
            OP_SUB: begin
                b_opnd = ~m;
                c_in   = cin;
            end
            OP_CMP: begin
                b_opnd = ~m;
                c_in   = 1'b1;
            end
            OP_INC: begin
                b_opnd = '0;
                c_in   = 1'b1;
            end
            OP_DEC: begin
                b_opnd = '1;
                c_in   = 1'b0;
            end
            default: begin
                b_opnd = m;
                c_in   = cin;
            end
        endcase
        sum  = {1'b0, a} + {1'b0, b_opnd} + {{WIDTH{1'b0}}, c_in};
        res  = sum[MSB:0];
        cout = sum[WIDTH];
        vout = (a[MSB] == b_opnd[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] m,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & m;
            OP_BIT:  res = a & m;
            OP_OR:   res = a | m;
            OP_XOR:  res = a ^ m;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        unique case (op)
            OP_SHL: begin
                res  = {a[MSB-1:0], 1'b0};
                cout = a[MSB];
            end
            OP_ROL: begin
                res  = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            OP_SHR: begin
                res  = {1'b0, a[MSB:1]};
                cout = a[0];
            end
            OP_ROR: begin
                res  = {cin, a[MSB:1]};
                cout = a[0];
            end
            default: begin
                res  = a;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
    import alu8_pkg::*;
(
    input  alu_op_e  op,
    output op_ctrl_t ctrl
);
    localparam flags_t NZ   = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
    localparam flags_t NZC  = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
    localparam flags_t NVZ  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
    localparam flags_t NVZC = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};

    always_comb begin
        ctrl = '{wmask: NZ, wr: 1'b1, src: SRC_LOGIC, bit_test: 1'b0};
        unique case (op)
            OP_ADD, OP_SUB: begin
                ctrl.wmask = NVZC;
                ctrl.src   = SRC_ARITH;
            end
            OP_CMP: begin
                ctrl.wmask = NZC;
                ctrl.src   = SRC_ARITH;
                ctrl.wr    = 1'b0;
            end
            OP_BIT: begin
                ctrl.wmask    = NVZ;
                ctrl.wr       = 1'b0;
                ctrl.bit_test = 1'b1;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                ctrl.wmask = NZC;
                ctrl.src   = SRC_SHIFT;
            end
            OP_INC, OP_DEC: begin
                ctrl.wmask = NZ;
                ctrl.src   = SRC_ARITH;
            end
            OP_NOP0, OP_NOP1: begin
                ctrl.wmask = '0;
                ctrl.wr    = 1'b0;
            end
            default: begin
                ctrl.wmask = NZ;
                ctrl.src   = SRC_LOGIC;
            end
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] reg_opnd,
    input  logic [WIDTH-1:0] mem_opnd,
    output logic [WIDTH-1:0] result,
    output logic             wr_result,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_z,
    output logic             flag_c
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t   state_d, state_q;
    alu_op_e  op_e;
    op_ctrl_t ctrl;

    logic [WIDTH-1:0] arith_res, logic_res, shift_res;
    logic             arith_c, arith_v, shift_c;
    flags_t           cand;

    assign op_e = alu_op_e'(op);

    alu8_ctrl u_ctrl (
        .op   (op_e),
        .ctrl (ctrl)
    );

    alu8_arith #(.WIDTH(WIDTH)) u_arith (
        .op   (op_e),
        .a    (reg_opnd),
        .m    (mem_opnd),
        .cin  (state_q.flags.c),
        .res  (arith_res),
        .cout (arith_c),
        .vout (arith_v)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .op  (op_e),
        .a   (reg_opnd),
        .m   (mem_opnd),
        .res (logic_res)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .op   (op_e),
        .a    (reg_opnd),
        .cin  (state_q.flags.c),
        .res  (shift_res),
        .cout (shift_c)
    );

    always_comb begin
        unique case (ctrl.src)
            SRC_ARITH: result = arith_res;
            SRC_SHIFT: result = shift_res;
            default:   result = logic_res;
        endcase
        wr_result = ctrl.wr;

        cand.n = ctrl.bit_test ? mem_opnd[MSB]   : result[MSB];
        cand.v = ctrl.bit_test ? mem_opnd[MSB-1] : arith_v;
        cand.z = (result == '0);
        cand.c = (ctrl.src == SRC_SHIFT) ? shift_c : arith_c;

        state_d = state_q;
        if (issue) begin
            state_d.flags.n = ctrl.wmask.n ? cand.n : state_q.flags.n;
            state_d.flags.v = ctrl.wmask.v ? cand.v : state_q.flags.v;
            state_d.flags.z = ctrl.wmask.z ? cand.z : state_q.flags.z;
            state_d.flags.c = ctrl.wmask.c ? cand.c : state_q.flags.c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_n = state_q.flags.n;
    assign flag_v = state_q.flags.v;
    assign flag_z = state_q.flags.z;
    assign flag_c = state_q.flags.c;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             issue,
    input logic [3:0]       op,
    input logic [WIDTH-1:0] reg_opnd,
    input logic [WIDTH-1:0] mem_opnd,
    input logic [WIDTH-1:0] result,
    input logic             wr_result,
    input logic             flag_n,
    input logic             flag_v,
    input logic             flag_z,
    input logic             flag_c
);
    localparam int MSB = WIDTH - 1;

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !issue |=> ($stable(flag_n) && $stable(flag_v) && $stable(flag_z) && $stable(flag_c)));

    assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd6) |-> !wr_result);

    assert_cmp_keeps_v_R4: assert property (@(posedge clk) disable iff (rst)
        (issue && op == 4'd6) |=> $stable(flag_v));

    assert_bit_copies_R5: assert property (@(posedge clk) disable iff (rst)
        (issue && op == 4'd7) |=>
            (flag_n == $past(mem_opnd[MSB]) && flag_v == $past(mem_opnd[MSB-1]) && $stable(flag_c)));

    assert_shr_clears_n_R6: assert property (@(posedge clk) disable iff (rst)
        (issue && op == 4'd9) |=> !flag_n);

    assert_incdec_keep_cv_R8: assert property (@(posedge clk) disable iff (rst)
        (issue && (op == 4'd12 || op == 4'd13)) |=> ($stable(flag_c) && $stable(flag_v)));

    assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (op >= 4'd14) |-> (result == reg_opnd && !wr_result));

    assert_nop_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (issue && op >= 4'd14) |=>
            ($stable(flag_n) && $stable(flag_v) && $stable(flag_z) && $stable(flag_c)));
endmodule

bind alu8_flags alu8_flags_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .op        (op),
    .reg_opnd  (reg_opnd),
    .mem_opnd  (mem_opnd),
    .result    (result),
    .wr_result (wr_result),
    .flag_n    (flag_n),
    .flag_v    (flag_v),
    .flag_z    (flag_z),
    .flag_c    (flag_c)
);

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       issue = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] reg_opnd = 8'd0;
    logic [7:0] mem_opnd = 8'd0;
    logic [7:0] result;
    logic       wr_result, flag_n, flag_v, flag_z, flag_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic m_n, m_v, m_z, m_c;

    always #2 clk = ~clk;

    alu8_flags u_alu8_flags (
        .clk(clk), .rst(rst), .issue(issue), .op(op),
        .reg_opnd(reg_opnd), .mem_opnd(mem_opnd),
        .result(result), .wr_result(wr_result),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
    );

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd6: return "R4";
            4'd7: return "R5";
            4'd8, 4'd9: return "R6";
            4'd10, 4'd11: return "R7";
            4'd14, 4'd15: return "R10";
            default: return "R8";
        endcase
    endfunction

    // Reference model: returns {wr, result} and updates next-flag outputs.
    function automatic logic [8:0] model(input logic [3:0] o, input logic [7:0] a,
                                         input logic [7:0] m, input logic ci,
                                         inout logic n, inout logic v,
                                         inout logic z, inout logic c);
        int s;
        logic [7:0] r;
        logic w;
        w = 1'b1;
        r = a;
        case (o)
            4'd1: begin
                s = int'(a) + int'(m) + int'(ci);
                r = s[7:0]; c = (s > 255);
                v = (a[7] == m[7]) && (r[7] != a[7]);
                n = r[7]; z = (r == 0);
            end
            4'd2: begin
                s = int'(a) - int'(m) - (1 - int'(ci));
                r = s[7:0]; c = (s >= 0);
                v = (a[7] != m[7]) && (r[7] != a[7]);
                n = r[7]; z = (r == 0);
            end
            4'd6: begin
                r = a - m; w = 1'b0;
                n = r[7]; z = (a == m); c = (a >= m);
            end
            4'd7: begin
                r = a & m; w = 1'b0;
                z = ((a & m) == 0); n = m[7]; v = m[6];
            end
            4'd8:  begin r = a << 1; c = a[7]; n = r[7]; z = (r == 0); end
            4'd9:  begin r = a >> 1; c = a[0]; n = 1'b0; z = (r == 0); end
            4'd10: begin r = {a[6:0], ci}; c = a[7]; n = r[7]; z = (r == 0); end
            4'd11: begin r = {ci, a[7:1]}; c = a[0]; n = r[7]; z = (r == 0); end
            4'd14, 4'd15: begin r = a; w = 1'b0; end
            default: begin
                case (o)
                    4'd3:  r = a & m;
                    4'd4:  r = a | m;
                    4'd5:  r = a ^ m;
                    4'd12: r = a + 8'd1;
                    4'd13: r = a - 8'd1;
                    default: r = a;
                endcase
                n = r[7]; z = (r == 0);
            end
        endcase
        return {w, r};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at negedge, check result, take edge, check flags.
    task automatic step(input logic iss, input logic [3:0] o,
                        input logic [7:0] a, input logic [7:0] m);
        logic [8:0] exp_wr;
        logic n, v, z, c;
        issue = iss; op = o; reg_opnd = a; mem_opnd = m;
        #1;
        n = m_n; v = m_v; z = m_z; c = m_c;
        exp_wr = model(o, a, m, m_c, n, v, z, c);
        check((o == 4'd6 || o == 4'd7 || o >= 4'd14) ? req_of(o) : "R11",
              "result/wr", {wr_result, result}, exp_wr);
        if (iss) begin
            m_n = n; m_v = v; m_z = z; m_c = c;
        end
        @(posedge clk);
        @(negedge clk);
        check(iss ? req_of(o) : "R9", "flags NVZC",
              {5'd0, flag_n, flag_v, flag_z, flag_c},
              {5'd0, m_n, m_v, m_z, m_c});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_n = 0; m_v = 0; m_z = 0; m_c = 0;
        // Dirty flags before reset so R1 is meaningful.
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset flags", {5'd0, flag_n, flag_v, flag_z, flag_c}, 9'd0);
        rst = 1'b0;
        step(1, 4'd8, 8'hFF, 8'h00);            // R6 sets C, N
        step(1, 4'd7, 8'h00, 8'hC0);            // R5 N,V from memory
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m_n = 0; m_v = 0; m_z = 0; m_c = 0;
        check("R1", "reset clears set flags", {5'd0, flag_n, flag_v, flag_z, flag_c}, 9'd0);

        // R2 overflow and carry, then chained multi-byte add
        step(1, 4'd1, 8'h7F, 8'h01);
        step(1, 4'd1, 8'hFF, 8'h01);
        step(1, 4'd1, 8'h10, 8'h20);            // consumes carry of previous
        // R3 subtract chain with borrow
        step(1, 4'd6, 8'h05, 8'h05);            // R4 equal -> C=1
        step(1, 4'd2, 8'h00, 8'h01);            // borrow -> C=0
        step(1, 4'd2, 8'h80, 8'h01);            // with borrow, V
        // R4 compare below/above
        step(1, 4'd6, 8'h03, 8'h05);
        step(1, 4'd6, 8'h09, 8'h05);
        // R5 bit test
        step(1, 4'd7, 8'h80, 8'h7F);
        // R6/R7 shifts and rotates with carry in
        step(1, 4'd9, 8'h81, 8'h00);
        step(1, 4'd10, 8'h40, 8'h00);
        step(1, 4'd11, 8'h01, 8'h00);
        step(1, 4'd11, 8'h00, 8'h00);
        // R8 inc/dec wrap
        step(1, 4'd12, 8'hFF, 8'h00);
        step(1, 4'd13, 8'h00, 8'h00);
        // R9 idle and R10 no-ops
        step(0, 4'd1, 8'hFF, 8'hFF);
        step(1, 4'd14, 8'h00, 8'h00);
        step(1, 4'd15, 8'h80, 8'h00);

        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 8) != 0, 4'($urandom), 8'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule